// File: doc/BRIEF.md
# Asynchronous Parallel Host Bus Slave

This block lets an external processor reach a small bank of internal 16-bit registers over an asynchronous parallel bus. The processor drives an active-low chip select, an active-low output enable, two active-low byte-lane strobes, a 4-bit word address and a 16-bit data bus. The bidirectional data bus is modelled as a separate input, output and output enable. Inside the block, all logic runs on a single interface clock.

The chip select, output enable and lane strobes each pass through a two-stage synchroniser. The synchronised levels are then decoded. A write is chip select low with at least one lane strobe low. On the first cycle of that condition, each byte lane whose strobe is low is stored into the addressed word exactly once. A read is chip select and output enable both low, with both lane strobes high. While a read lasts, the addressed word is driven onto the data output and the output enable is raised. The bus is released one clock after the synchronised read condition ends.

Top module: `host_bus_slave`

## Requirements
- R1: After reset, `dataOe` is 0 and every one of the 16 words reads back as 0x0000.
- R2: With `csN`=0 and both `beN` bits 0, a write stores all 16 bits of `dataIn` into the word selected by `addr`.
- R3: `beN[0]`=0 enables bits 7:0 and `beN[1]`=0 enables bits 15:8. A lane whose strobe stays 1 keeps its previous contents.
- R4: A write is committed once per strobe assertion. A change of `dataIn` while the strobes stay low does not alter the stored word.
- R5: Lane strobes asserted while `csN`=1 write nothing.
- R6: With `csN`=0, `oeN`=0 and `beN`=2'b11 held, `dataOe` is 1 and `dataOut` equals the addressed word no later than the third rising clock edge after the inputs are applied.
- R7: `dataOe` stays 0 when `csN`=1, when `oeN`=1, or when any `beN` bit is 0. In that last case a write takes place instead, even with `oeN`=0.
- R8: After the read inputs are released, `dataOe` returns to 0 no later than the third rising clock edge.
- R9: Each of the 16 addresses selects its own word. A write to one address leaves the other words unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rstN | input | 1 | Active-low reset |
| csN | input | 1 | Chip select, active low, asynchronous |
| oeN | input | 1 | Output enable, active low, asynchronous |
| beN | input | 2 | Byte-lane write strobes, active low; bit 0 is the low byte |
| addr | input | 4 | Word address |
| dataIn | input | 16 | Data bus as driven by the host |
| dataOut | output | 16 | Data bus as driven by the block |
| dataOe | output | 1 | Drive enable for the data bus pads |

## Verification
The main sweep writes a distinct full-word pattern to every address and then reads all 16 back. A wrong or aliased address decode shows up as a mismatch at some other word. Separate low-lane and high-lane writes to each address, each with a fresh pattern, tell a swapped or ignored lane strobe apart from a correct merge. Further patterns cover strobes asserted without chip select, data changed during a held strobe, and a lane strobe combined with output enable low. These separate cycle decoding faults from commit-once faults. Reads with chip select or output enable held high check that the bus stays released.

// File: rtl/hbs_pkg.sv
package hbs_pkg;
  parameter int HBS_LANES = 2;

  typedef struct packed {
    logic                 wrCommit;
    logic [HBS_LANES-1:0] laneEn;
    logic                 rdActive;
  } hbsStrobe_t;
endpackage

// File: rtl/hbs_sync.sv
module hbs_sync #(
  parameter int W      = 1,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] asyncIn,
  output logic [W-1:0] syncOut
);
  // strobes are active low, so the idle value is all ones
  logic [W-1:0] chain [STAGES];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < STAGES; i++) chain[i] <= '1;
    end else begin
      chain[0] <= asyncIn;
      for (int i = 1; i < STAGES; i++) chain[i] <= chain[i-1];
    end
  end

  assign syncOut = chain[STAGES-1];
endmodule

// File: rtl/hbs_ctrl.sv
module hbs_ctrl import hbs_pkg::*; #(
  parameter int SYNC_STAGES = 2
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 csN,
  input  logic                 oeN,
  input  logic [HBS_LANES-1:0] beN,
  output hbsStrobe_t           strb
);
  localparam int SW = 2 + HBS_LANES;

  logic [SW-1:0]        syncVec;
  logic                 csS, oeS;
  logic [HBS_LANES-1:0] beS;
  logic                 wrCond, rdCond, wrCondQ;

  hbs_sync #(.W(SW), .STAGES(SYNC_STAGES)) syncI (
    .clk(clk), .rstN(rstN), .asyncIn({csN, oeN, beN}), .syncOut(syncVec)
  );

  assign {csS, oeS, beS} = syncVec;
  assign wrCond = !csS && (beS != '1);
  assign rdCond = !csS && !oeS && (beS == '1);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) wrCondQ <= 1'b0;
    else       wrCondQ <= wrCond;
  end

  assign strb.wrCommit = wrCond && !wrCondQ;
  assign strb.laneEn   = ~beS;
  assign strb.rdActive = rdCond;

  assert_commit_once_R4: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |=> !strb.wrCommit);
  assert_commit_has_lane_R2: assert property (@(posedge clk) disable iff (!rstN)
    strb.wrCommit |-> (strb.laneEn != '0));
  assert_rd_wr_exclusive_R7: assert property (@(posedge clk) disable iff (!rstN)
    !(strb.rdActive && strb.wrCommit));
endmodule

// File: rtl/hbs_datapath.sv
module hbs_datapath import hbs_pkg::*; #(
  parameter int ADDR_W = 4
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  hbsStrobe_t             strb,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [8*HBS_LANES-1:0] dataIn,
  output logic [8*HBS_LANES-1:0] dataOut,
  output logic                   dataOe
);
  localparam int DW    = 8 * HBS_LANES;
  localparam int DEPTH = 1 << ADDR_W;

  logic [DEPTH-1:0][DW-1:0] bank;
  logic [DW-1:0]            wrMask;

  for (genvar g = 0; g < HBS_LANES; g++) begin : gLane
    assign wrMask[g*8 +: 8] = {8{strb.laneEn[g]}};
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bank <= '0;
    end else if (strb.wrCommit) begin
      bank[addr] <= (bank[addr] & ~wrMask) | (dataIn & wrMask);
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= strb.rdActive ? bank[addr] : '0;
      dataOe  <= strb.rdActive;
    end
  end

  assert_oe_from_read_R6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(dataOe) |-> $past(strb.rdActive));
  assert_bank_hold_R4: assert property (@(posedge clk) disable iff (!rstN)
    !strb.wrCommit |=> $stable(bank));
  assert_low_lane_keep_R3: assert property (@(posedge clk) disable iff (!rstN)
    (strb.wrCommit && !strb.laneEn[0]) |=> (bank[$past(addr)][7:0] == $past(bank[addr][7:0])));
endmodule

// File: rtl/host_bus_slave.sv
module host_bus_slave import hbs_pkg::*; #(
  parameter int ADDR_W      = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   csN,
  input  logic                   oeN,
  input  logic [HBS_LANES-1:0]   beN,
  input  logic [ADDR_W-1:0]      addr,
  input  logic [8*HBS_LANES-1:0] dataIn,
  output logic [8*HBS_LANES-1:0] dataOut,
  output logic                   dataOe
);
  hbsStrobe_t strb;

  hbs_ctrl #(.SYNC_STAGES(SYNC_STAGES)) ctrlI (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .beN(beN), .strb(strb)
  );

  hbs_datapath #(.ADDR_W(ADDR_W)) dpI (
    .clk(clk), .rstN(rstN), .strb(strb), .addr(addr), .dataIn(dataIn),
    .dataOut(dataOut), .dataOe(dataOe)
  );
endmodule

// File: tb/host_bus_slave_tb_top.sv
module host_bus_slave_tb_top;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        csN = 1'b1, oeN = 1'b1;
  logic [1:0]  beN = 2'b11;
  logic [3:0]  addr = '0;
  logic [15:0] dataIn = '0;
  logic [15:0] dataOut;
  logic        dataOe;

  int vecs = 0, errs = 0;
  bit done = 1'b0;
  logic [15:0] model [16];

  always #10 clk = ~clk;

  host_bus_slave dut_i (
    .clk(clk), .rstN(rstN), .csN(csN), .oeN(oeN), .beN(beN), .addr(addr),
    .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe)
  );

  task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
    vecs++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [15:0] merge(input logic [15:0] old, input logic [15:0] d, input logic [1:0] be);
    logic [15:0] m;
    m = {{8{~be[1]}}, {8{~be[0]}}};
    return (old & ~m) | (d & m);
  endfunction

  task automatic busWrite(input logic [3:0] a, input logic [15:0] d, input logic [1:0] be);
    addr = a; dataIn = d; csN = 1'b0; beN = be;
    idle(4);
    csN = 1'b1; beN = 2'b11;
    idle(3);
    model[a] = merge(model[a], d, be);
  endtask

  task automatic busRead(input logic [3:0] a, input string req);
    addr = a; csN = 1'b0; oeN = 1'b0; beN = 2'b11;
    idle(3);
    check({req, " oe"}, {15'd0, dataOe}, 16'd1);
    check(req, dataOut, model[a]);
    csN = 1'b1; oeN = 1'b1;
    idle(3);
    check("R8 release", {15'd0, dataOe}, 16'd0);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errs++;
      $display("FAIL watchdog: got running expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) model[i] = '0;
    idle(3);
    check("R1 oe at reset", {15'd0, dataOe}, 16'd0);
    rstN = 1'b1;
    idle(2);
    for (int i = 0; i < 16; i++) busRead(4'(i), "R1 reset contents");

    // R2/R9: full-word write to every address, then read all back
    for (int i = 0; i < 16; i++) busWrite(4'(i), 16'(i * 16'h1111) ^ 16'hA5C3, 2'b00);
    for (int i = 0; i < 16; i++) busRead(4'(i), "R2 R9 full word");

    // R3: low lane then high lane per address
    for (int i = 0; i < 16; i++) begin
      busWrite(4'(i), 16'(16'h3C00 + i * 16'h0107), 2'b10);
      busRead(4'(i), "R3 low lane");
      busWrite(4'(i), 16'(16'h00E1 + i * 16'h0B00), 2'b01);
      busRead(4'(i), "R3 high lane");
    end

    // R5: strobes without chip select
    addr = 4'd5; dataIn = 16'hDEAD; beN = 2'b00;
    idle(5);
    beN = 2'b11;
    idle(3);
    busRead(4'd5, "R5 no cs write");

    // R4: data changed while strobes held
    addr = 4'd7; dataIn = 16'h1234; csN = 1'b0; beN = 2'b00;
    idle(4);
    dataIn = 16'hFFFF;
    idle(4);
    csN = 1'b1; beN = 2'b11;
    idle(3);
    model[7] = 16'h1234;
    busRead(4'd7, "R4 single commit");

    // R7: no drive with cs high or oe high
    addr = 4'd7; csN = 1'b1; oeN = 1'b0;
    idle(4);
    check("R7 cs high", {15'd0, dataOe}, 16'd0);
    csN = 1'b0; oeN = 1'b1;
    idle(4);
    check("R7 oe high", {15'd0, dataOe}, 16'd0);
    // R7: lane strobe with oe low is a write, never drives
    addr = 4'd9; dataIn = 16'h5A5A; beN = 2'b10; oeN = 1'b0;
    idle(4);
    check("R7 write with oe low", {15'd0, dataOe}, 16'd0);
    csN = 1'b1; oeN = 1'b1; beN = 2'b11;
    idle(3);
    model[9] = merge(model[9], 16'h5A5A, 2'b10);
    busRead(4'd9, "R7 write took place");

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule